// File: doc/BRIEF.md
# Security Attribution and Gateway Entry Checker

This block sits between a processor's access port and its memory protection stage. For every access it looks up the target address in a table of programmable regions and gives it one of three labels: non-secure, secure, or non-secure-callable. Non-secure-callable is a secure area that non-secure code may enter. The block combines that label with the requester's current security state and the kind of access (instruction fetch, data read, data write). From these it decides whether the access may proceed.

Accepted accesses leave one cycle later. They carry a protection bit that marks them as secure or non-secure on the downstream bus. The same bit picks which of the two protection-unit banks checks the access next.

Rejected accesses are not forwarded. They raise a one-cycle fault pulse, and the first faulting address is latched in a status register. A non-secure fetch into secure memory is the single way non-secure code can enter secure code. It is accepted only when it lands in a non-secure-callable region and the fetched word equals the gateway opcode. The block flags such an accepted entry.

Top module: `sec_attr_gate`

## Requirements
- R1: After reset, out_valid, out_fault, out_gateway and fault_pending are 0, fault_addr is 0, and no region is enabled.
- R2: Region configuration is written with cfg_we, cfg_idx and cfg_sel. cfg_sel 0 writes the base and cfg_sel 1 writes the limit. In both cases bits [4:0] of cfg_wdata are ignored, so regions sit on 32-byte blocks. cfg_sel 2 writes control: bit0 is enable and bit1 is callable.
- R3: An enabled region matches an address whose 32-byte block lies between its base block and its limit block, both ends included. out_attr encodes non-secure as 0, secure as 1 and non-secure-callable as 2. A matching region with the callable bit at 1 gives 2; with the callable bit at 0 it gives 0.
- R4: An address matched by no enabled region is secure (out_attr 1). A disabled region has no effect on any address.
- R5: When regions overlap, the lowest-numbered enabled matching region decides out_attr.
- R6: A data access (acc_kind 1 read, 2 write) made with acc_ns 1 to a secure or callable address produces out_fault 1 and out_valid 0.
- R7: An access made with acc_ns 0 never faults, whatever the attribute of its target.
- R8: For an accepted access, out_prot_ns is 1 when the target is non-secure and 0 when it is secure or callable. This bit also selects the protection bank.
- R9: A fetch (acc_kind 0) made with acc_ns 1 into secure or callable memory is accepted, with out_gateway 1, only when the target is callable and acc_insn equals the gateway opcode. Every other such fetch faults. A non-secure fetch into non-secure memory is accepted with out_gateway 0.
- R10: On a fault, fault_pending is set and fault_addr captures the address. Later faults leave fault_addr unchanged until a write with cfg_sel 3 clears both. If a clear and a fault occur in the same cycle, the new fault is captured.
- R11: Outputs appear in the cycle after the access is presented. out_fault is high for one cycle per faulting access, and an idle cycle gives out_valid 0 and out_fault 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region number written |
| cfg_sel | input | 2 | 0 base, 1 limit, 2 control, 3 clear fault status |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write |
| acc_ns | input | 1 | Requester is in the non-secure state |
| acc_insn | input | 32 | Fetched instruction word, used for fetches |
| out_valid | output | 1 | Access forwarded downstream |
| out_attr | output | 2 | Attribute of the target: 0 non-secure, 1 secure, 2 callable |
| out_prot_ns | output | 1 | Bus protection bit and bank select: 1 non-secure |
| out_fault | output | 1 | One-cycle fault pulse |
| out_gateway | output | 1 | Accepted non-secure entry through a gateway |
| fault_pending | output | 1 | Fault status valid |
| fault_addr | output | 32 | Address of the first fault since the last clear |

## Verification
The assertions assume that acc_kind never takes the unused value 3. They also assume that region contents do not change in the same cycle as an access whose outcome is being checked. The bench keeps to both: every configuration write completes before the next access is driven. The one deliberate overlap is a status clear issued together with a fault, which is the case R10 defines. Region limits are always programmed at or above their bases, so every programmed region covers a real span.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        ATTR_NS  = 2'd0,
        ATTR_S   = 2'd1,
        ATTR_NSC = 2'd2
    } attr_e;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        CFG_BASE  = 2'd0,
        CFG_LIMIT = 2'd1,
        CFG_CTRL  = 2'd2,
        CFG_CLEAR = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/sag_region_bank.sv
module sag_region_bank #(
    parameter int NUM_REG   = 8,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 5,
    localparam int BLK_W    = ADDR_W - GRAN_LOG2,
    localparam int IDX_W    = $clog2(NUM_REG)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [IDX_W-1:0]                  idx_i,
    input  logic [1:0]                        sel_i,
    input  logic [ADDR_W-1:0]                 wdata_i,
    output logic [NUM_REG-1:0]                en_o,
    output logic [NUM_REG-1:0]                nsc_o,
    output logic [NUM_REG-1:0][BLK_W-1:0]     base_o,
    output logic [NUM_REG-1:0][BLK_W-1:0]     limit_o
);
    import sag_pkg::*;

    typedef struct packed {
        logic             en;
        logic             nsc;
        logic [BLK_W-1:0] base;
        logic [BLK_W-1:0] limit;
    } region_t;

    region_t [NUM_REG-1:0] st_d, st_q;

    logic unused_bits;
    assign unused_bits = ^wdata_i[GRAN_LOG2-1:2];

    always_comb begin
        st_d = st_q;
        if (we_i && (int'(idx_i) < NUM_REG)) begin
            case (cfg_sel_e'(sel_i))
                CFG_BASE:  st_d[idx_i].base  = wdata_i[ADDR_W-1:GRAN_LOG2];
                CFG_LIMIT: st_d[idx_i].limit = wdata_i[ADDR_W-1:GRAN_LOG2];
                CFG_CTRL: begin
                    st_d[idx_i].en  = wdata_i[0];
                    st_d[idx_i].nsc = wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_REG; g++) begin : g_out
        assign en_o[g]    = st_q[g].en;
        assign nsc_o[g]   = st_q[g].nsc;
        assign base_o[g]  = st_q[g].base;
        assign limit_o[g] = st_q[g].limit;
    end

    AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == 2'd2) |=> (en_o[$past(idx_i)] == $past(wdata_i[0])) &&
                                     (nsc_o[$past(idx_i)] == $past(wdata_i[1]))); // R2

endmodule

// File: rtl/sag_lookup.sv
module sag_lookup #(
    parameter int NUM_REG   = 8,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 5,
    localparam int BLK_W    = ADDR_W - GRAN_LOG2
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [NUM_REG-1:0]            en_i,
    input  logic [NUM_REG-1:0]            nsc_i,
    input  logic [NUM_REG-1:0][BLK_W-1:0] base_i,
    input  logic [NUM_REG-1:0][BLK_W-1:0] limit_i,
    output sag_pkg::attr_e                attr_o,
    output logic                          hit_o
);
    import sag_pkg::*;

    logic [BLK_W-1:0]   blk;
    logic [NUM_REG-1:0] hit_v;
    logic               unused_low;

    assign blk        = addr_i[ADDR_W-1:GRAN_LOG2];
    assign unused_low = ^addr_i[GRAN_LOG2-1:0];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_match
        assign hit_v[g] = en_i[g] && (blk >= base_i[g]) && (blk <= limit_i[g]);
    end

    always_comb begin
        attr_o = ATTR_S;
        hit_o  = 1'b0;
        for (int i = NUM_REG - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                attr_o = nsc_i[i] ? ATTR_NSC : ATTR_NS;
                hit_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sag_fault_status.sv
module sag_fault_status #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_i,
    output logic              pend_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d = '0;
        if (fault_i && !st_d.pend) begin
            st_d.pend = 1'b1;
            st_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign addr_o = st_q.addr;

    AST_FAULT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> (pend_o && $stable(addr_o))); // R10

    AST_FAULT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> pend_o); // R10

endmodule

// File: rtl/sec_attr_gate.sv
module sec_attr_gate #(
    parameter int          NUM_REG   = 8,
    parameter int          ADDR_W    = 32,
    parameter int          GRAN_LOG2 = 5,
    parameter int          INSN_W    = 32,
    parameter logic [31:0] GATE_OP   = 32'hB00C_5EC1,
    localparam int         IDX_W     = $clog2(NUM_REG),
    localparam int         BLK_W     = ADDR_W - GRAN_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_ns,
    input  logic [INSN_W-1:0] acc_insn,
    output logic              out_valid,
    output logic [1:0]        out_attr,
    output logic              out_prot_ns,
    output logic              out_fault,
    output logic              out_gateway,
    output logic              fault_pending,
    output logic [ADDR_W-1:0] fault_addr
);
    import sag_pkg::*;

    typedef struct packed {
        logic  valid;
        attr_e attr;
        logic  prot_ns;
        logic  fault;
        logic  gateway;
    } resp_t;

    logic [NUM_REG-1:0]            rg_en, rg_nsc;
    logic [NUM_REG-1:0][BLK_W-1:0] rg_base, rg_limit;
    attr_e                         lk_attr;
    logic                          lk_hit;
    logic                          clr;
    resp_t                         rs_d, rs_q;

    sag_region_bank #(
        .NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)
    ) i_bank (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .idx_i(cfg_idx),
        .sel_i(cfg_sel), .wdata_i(cfg_wdata), .en_o(rg_en), .nsc_o(rg_nsc),
        .base_o(rg_base), .limit_o(rg_limit)
    );

    sag_lookup #(
        .NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)
    ) i_lookup (
        .addr_i(acc_addr), .en_i(rg_en), .nsc_i(rg_nsc), .base_i(rg_base),
        .limit_i(rg_limit), .attr_o(lk_attr), .hit_o(lk_hit)
    );

    always_comb begin
        logic is_fetch, to_secure, gate_ok, bad;
        is_fetch  = (acc_kind == KIND_FETCH);
        to_secure = (lk_attr != ATTR_NS);
        gate_ok   = is_fetch && (lk_attr == ATTR_NSC) && (acc_insn == GATE_OP[INSN_W-1:0]);
        bad       = acc_ns && to_secure && !gate_ok;

        rs_d         = '0;
        rs_d.attr    = lk_attr;
        if (acc_valid) begin
            rs_d.fault   = bad;
            rs_d.valid   = !bad;
            rs_d.prot_ns = !bad && !to_secure;
            rs_d.gateway = acc_ns && gate_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '{valid: 1'b0, attr: ATTR_S, prot_ns: 1'b0, fault: 1'b0, gateway: 1'b0};
        else        rs_q <= rs_d;
    end

    assign clr = cfg_we && (cfg_sel == CFG_CLEAR);

    sag_fault_status #(.ADDR_W(ADDR_W)) i_status (
        .clk(clk), .rst_n(rst_n), .fault_i(rs_d.fault), .addr_i(acc_addr),
        .clr_i(clr), .pend_o(fault_pending), .addr_o(fault_addr)
    );

    assign out_valid   = rs_q.valid;
    assign out_attr    = rs_q.attr;
    assign out_prot_ns = rs_q.prot_ns;
    assign out_fault   = rs_q.fault;
    assign out_gateway = rs_q.gateway;

    AST_NS_DATA_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ns && acc_kind != 2'd0 && lk_attr != ATTR_NS)
        |=> (out_fault && !out_valid)); // R6

    AST_SEC_NEVER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ns) |=> (!out_fault && out_valid)); // R7

    AST_PROT_ONLY_NS: assert property (@(posedge clk) disable iff (!rst_n)
        out_prot_ns |-> (out_valid && out_attr == 2'd0)); // R8

    AST_GATE_IN_NSC: assert property (@(posedge clk) disable iff (!rst_n)
        out_gateway |-> (out_attr == 2'd2 && out_valid && !out_fault)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!out_valid && !out_fault && !out_gateway)); // R11

    AST_UNMATCHED_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !lk_hit) |=> (out_attr == 2'd1)); // R4

endmodule

// File: tb/test_sec_attr_gate.sv
module test_sec_attr_gate;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] GATE       = 32'hB00C_5EC1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_ns = 1'b0;
    logic [31:0] acc_insn = '0;
    logic        out_valid, out_prot_ns, out_fault, out_gateway, fault_pending;
    logic [1:0]  out_attr;
    logic [31:0] fault_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_attr_gate #(.GATE_OP(GATE)) i_sec_attr_gate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_ns(acc_ns),
        .acc_insn(acc_insn), .out_valid(out_valid), .out_attr(out_attr),
        .out_prot_ns(out_prot_ns), .out_fault(out_fault),
        .out_gateway(out_gateway), .fault_pending(fault_pending),
        .fault_addr(fault_addr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(logic [2:0] idx, logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic region(logic [2:0] idx, logic [31:0] b, logic [31:0] l, logic [1:0] ctl);
        cfg(idx, 2'd0, b);
        cfg(idx, 2'd1, l);
        cfg(idx, 2'd2, {30'd0, ctl});
    endtask

    // drive one access at a falling edge, sample after the next rising edge
    task automatic acc(logic [31:0] a, logic [1:0] k, logic ns, logic [31:0] insn);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_ns = ns; acc_insn = insn;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic expect_out(string tag, logic v, logic [1:0] at, logic p, logic f, logic g);
        chk({tag, " valid"}, 32'(out_valid), 32'(v));
        chk({tag, " attr"}, 32'(out_attr), 32'(at));
        chk({tag, " prot"}, 32'(out_prot_ns), 32'(p));
        chk({tag, " fault"}, 32'(out_fault), 32'(f));
        chk({tag, " gate"}, 32'(out_gateway), 32'(g));
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 fault", 32'(out_fault), 0);
        chk("R1 gate", 32'(out_gateway), 0);
        chk("R1 pend", 32'(fault_pending), 0);
        chk("R1 faddr", fault_addr, 0);
        acc(32'h0000_0100, 2'd1, 1'b0, 0);
        expect_out("R1 R4 empty table secure", 1, 2'd1, 0, 0, 0);
    endtask

    task automatic t_region();
        region(3'd3, 32'h2000_0010, 32'h2000_0FE0, 2'b01);
        acc(32'h2000_0000, 2'd1, 1'b1, 0);
        expect_out("R2 R3 base low bits ignored", 1, 2'd0, 1, 0, 0);
        acc(32'h2000_0FFF, 2'd2, 1'b1, 0);
        expect_out("R3 limit block inclusive", 1, 2'd0, 1, 0, 0);
        acc(32'h2000_1000, 2'd0, 1'b0, 0);
        expect_out("R3 R4 past limit secure", 1, 2'd1, 0, 0, 0);
    endtask

    task automatic t_disabled();
        region(3'd5, 32'h3000_0000, 32'h3000_FFE0, 2'b10);
        acc(32'h3000_0100, 2'd1, 1'b0, 0);
        expect_out("R4 disabled region ignored", 1, 2'd1, 0, 0, 0);
    endtask

    task automatic t_overlap();
        region(3'd1, 32'h4000_0000, 32'h4000_00E0, 2'b11);
        region(3'd2, 32'h4000_0000, 32'h4000_FFE0, 2'b01);
        acc(32'h4000_0040, 2'd1, 1'b0, 0);
        expect_out("R5 low index callable wins", 1, 2'd2, 0, 0, 0);
        acc(32'h4000_0200, 2'd1, 1'b0, 0);
        expect_out("R5 outer region only", 1, 2'd0, 1, 0, 0);
        region(3'd0, 32'h4000_0000, 32'h4000_00E0, 2'b01);
        acc(32'h4000_0040, 2'd1, 1'b0, 0);
        expect_out("R5 region0 overrides", 1, 2'd0, 1, 0, 0);
        cfg(3'd0, 2'd2, 32'd0);
        acc(32'h4000_0040, 2'd1, 1'b0, 0);
        expect_out("R5 region0 off again", 1, 2'd2, 0, 0, 0);
    endtask

    task automatic t_ns_fault();
        acc(32'h0000_0100, 2'd2, 1'b1, 0);
        expect_out("R6 ns write secure", 0, 2'd1, 0, 1, 0);
        chk("R10 pend set", 32'(fault_pending), 1);
        chk("R10 addr captured", fault_addr, 32'h0000_0100);
        @(negedge clk);
        chk("R11 fault pulse ends", 32'(out_fault), 0);
        chk("R11 idle no valid", 32'(out_valid), 0);
        acc(32'h4000_0040, 2'd1, 1'b1, 0);
        expect_out("R6 ns read callable", 0, 2'd2, 0, 1, 0);
        chk("R10 first addr held", fault_addr, 32'h0000_0100);
        cfg(3'd0, 2'd3, 32'd0);
        chk("R10 clear pend", 32'(fault_pending), 0);
        chk("R10 clear addr", fault_addr, 0);
    endtask

    task automatic t_secure();
        acc(32'h4000_0040, 2'd2, 1'b0, 0);
        expect_out("R7 R8 secure write callable", 1, 2'd2, 0, 0, 0);
        acc(32'h2000_0100, 2'd1, 1'b0, 0);
        expect_out("R7 R8 secure read ns memory", 1, 2'd0, 1, 0, 0);
        acc(32'h0000_0800, 2'd0, 1'b0, 32'h1234_5678);
        expect_out("R7 secure fetch secure", 1, 2'd1, 0, 0, 0);
        chk("R7 no pending", 32'(fault_pending), 0);
    endtask

    task automatic t_gateway();
        acc(32'h4000_0040, 2'd0, 1'b1, GATE);
        expect_out("R9 legal gateway", 1, 2'd2, 0, 0, 1);
        acc(32'h4000_0044, 2'd0, 1'b1, GATE ^ 32'h1);
        expect_out("R9 wrong opcode", 0, 2'd2, 0, 1, 0);
        chk("R10 gateway fault addr", fault_addr, 32'h4000_0044);
        acc(32'h0000_0500, 2'd0, 1'b1, GATE);
        expect_out("R9 opcode in plain secure", 0, 2'd1, 0, 1, 0);
        acc(32'h2000_0100, 2'd0, 1'b1, GATE);
        expect_out("R9 ns fetch ns memory", 1, 2'd0, 1, 0, 0);
        acc(32'h4000_0040, 2'd1, 1'b1, GATE);
        expect_out("R9 R6 read of gateway word", 0, 2'd2, 0, 1, 0);
    endtask

    task automatic t_clear_vs_fault();
        chk("R10 pend before", 32'(fault_pending), 1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_idx = 3'd0; cfg_wdata = 0;
        acc_valid = 1'b1; acc_addr = 32'h0000_0600; acc_kind = 2'd1; acc_ns = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        chk("R10 clear+fault pend", 32'(fault_pending), 1);
        chk("R10 clear+fault addr", fault_addr, 32'h0000_0600);
        chk("R11 clear+fault pulse", 32'(out_fault), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_region();
        t_disabled();
        t_overlap();
        t_ns_fault();
        t_secure();
        t_gateway();
        t_clear_vs_fault();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule